// File: doc/BRIEF.md
# Segmented Packet Reassembler with Per-Segment CRC-10

This block rebuilds variable-length packets from a stream of fixed 48-byte segments that all belong to one virtual circuit. Each segment carries a two-byte header (segment type, 4-bit sequence number, message identifier) and a two-byte trailer (6-bit length indicator, CRC-10). The block takes the segment in one byte per accepted cycle, keeps the 44-byte data field in a local buffer, and checks the CRC and the sequence number when the last byte arrives. It then sends the valid data bytes out as a byte stream. The segment type codes mark where packets begin and end. Every packet that is closed ends with a single completion beat that carries an error flag.

The block drops header and trailer bytes. It forwards only as many data bytes as the length indicator gives, joining segments in the order they arrive. A CRC mismatch or a sequence gap does not throw the data away. It marks the packet as errored, and the flag is reported on the completion beat. Continue or end segments that arrive while no packet is open are discarded and counted. A begin segment that arrives while a packet is still open aborts that packet: a completion beat with the error flag set is emitted before the new packet's data.

The emission side is a four-state machine. IDLE waits for the trailer of a segment. CLOSE emits the abort beat for an open packet that a begin or single segment has interrupted. DATA emits the buffered bytes, one per cycle. DONE emits the completion beat of a packet that an end or single segment has closed. The transitions are:
- IDLE to CLOSE when an accepted begin or single segment finds a packet open.
- IDLE to DATA when the segment carries data.
- IDLE to DONE when an end or single segment carries no data.
- CLOSE to DATA, DONE or IDLE, according to the new segment's data and type.
- DATA to DONE or IDLE after its last byte.
- DONE to IDLE.

Top module: `sar_reassembler`

## Requirements
- R1: After reset, out_valid, pkt_done and pkt_err are 0, and proto_errs is 0.
- R2: Segment byte 0 holds the type in bits [7:6] and the sequence number in bits [5:2]. Bytes 2 to 45 are the data field. Byte 46 holds the length indicator in bits [7:2]. Only data-field bytes 2, 3, ... up to the length are forwarded, in order, and header and trailer bytes are never output.
- R3: A length indicator above 44 forwards all 44 data bytes.
- R4: The type codes are 2'b10 begin, 2'b00 continue, 2'b01 end and 2'b11 single. out_sop marks the first byte forwarded after a begin or single segment. An end or single segment closes the packet with one pkt_done beat, and no data byte is ever output in the same cycle as pkt_done.
- R5: The CRC-10 uses the polynomial x^10+x^9+x^5+x^4+x+1 with a zero start value. It runs over all 384 segment bits, MSB of byte 0 first, and is good when the remainder is zero. The sender places the remainder of the first 374 bits in byte 46 bits [1:0] and byte 47. A bad CRC sets pkt_err on that packet's completion beat, but the segment's data is still forwarded.
- R6: Apart from the first complete segment after reset, a segment whose sequence number is not the previous complete segment's number plus 1 (mod 16) sets pkt_err on the packet it belongs to. Dropped segments also update the previous number.
- R7: A continue or end segment that arrives with no packet open produces no output and adds 1 to proto_errs. proto_errs saturates at its all-ones value.
- R8: A begin or single segment that arrives with a packet open first emits pkt_done with pkt_err=1, and then starts the new packet.
- R9: pkt_err is only 1 together with pkt_done. When an end or single segment carries data, its pkt_done comes in the cycle right after its last data byte. A closing segment with no data still produces pkt_done.
- R10: The first forwarded byte of a segment appears in the cycle after its last byte is accepted, or one cycle later when an abort beat comes first. The bytes of a segment appear in consecutive cycles, and a segment's output is finished before the next segment's last byte is accepted.
- R11: A byte with in_valid and in_first is byte 0 of a new segment, and it abandons any partial segment. Bytes with in_valid but without in_first are ignored while no segment is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_first | input | 1 | Input byte is byte 0 of a segment |
| in_byte | input | 8 | Segment byte |
| out_valid | output | 1 | Forwarded data byte present |
| out_byte | output | 8 | Forwarded data byte |
| out_sop | output | 1 | First byte of a packet |
| pkt_done | output | 1 | Packet completion beat |
| pkt_err | output | 1 | Packet errored, qualified by pkt_done |
| proto_errs | output | CNT_W | Saturating count of dropped stray segments |

## Verification
A wrong open-packet flag shows up at the ports within one segment time. Either a stray continue segment produces data, or a begin segment is missing its abort beat, and proto_errs moves in the wrong direction. A stale sequence number or CRC remainder only shows on the error flag of the next completion beat, which may be several segments later. So the bench compares every completion beat against its own model of packet state, under random types, gaps and corruptions. Buffer or read-index faults show in the next emitted byte, and the bench compares each byte and its emission cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SEG_COM = 2'b00,
        SEG_EOM = 2'b01,
        SEG_BOM = 2'b10,
        SEG_SSM = 2'b11
    } seg_type_e;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_CLOSE,
        EM_DATA,
        EM_DONE
    } em_state_e;

    localparam logic [9:0] CRC10_POLY = 10'h233;

    // Advance a CRC-10 remainder by one byte, MSB first.
    function automatic logic [9:0] crc10_step(input logic [9:0] rem, input logic [7:0] d);
        logic [9:0] r;
        logic       fb;
        r = rem;
        for (int i = 7; i >= 0; i--) begin
            fb = r[9] ^ d[i];
            r  = {r[8:0], 1'b0};
            if (fb) r = r ^ CRC10_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/sar_crc10.sv
module sar_crc10
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       first,
    input  logic [7:0] din,
    output logic       rem_zero
);

    logic [9:0] rem_q;
    logic [9:0] rem_nx;

    always_comb begin
        rem_nx   = crc10_step(first ? 10'd0 : rem_q, din);
        rem_zero = (rem_nx == 10'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else if (en) rem_q <= rem_nx;
    end

endmodule

// File: rtl/sar_seg_buf.sv
module sar_seg_buf #(
    parameter int DEPTH = 44,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sar_reassembler.sv
module sar_reassembler
    import sar_pkg::*;
#(
    parameter int DATA_BYTES = 44,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sop,
    output logic             pkt_done,
    output logic             pkt_err,
    output logic [CNT_W-1:0] proto_errs
);

    localparam int HDR_BYTES = 2;
    localparam int SEG_BYTES = DATA_BYTES + 4;
    localparam int POS_W     = $clog2(SEG_BYTES);
    localparam int AW        = $clog2(DATA_BYTES);
    localparam int LI_W      = 6;
    localparam logic [POS_W-1:0] POS_D0   = POS_W'(HDR_BYTES);
    localparam logic [POS_W-1:0] POS_DEND = POS_W'(HDR_BYTES + DATA_BYTES);
    localparam logic [POS_W-1:0] POS_LI   = POS_W'(SEG_BYTES - 2);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SEG_BYTES - 1);
    localparam logic [LI_W-1:0]  LI_MAX   = LI_W'(DATA_BYTES);

    // receive side
    logic             rx_act;
    logic [POS_W-1:0] rx_pos;
    logic [POS_W-1:0] byte_pos;
    logic             take;
    logic             seg_end;
    seg_type_e        hdr_type;
    logic [3:0]       hdr_sn;
    logic [LI_W-1:0]  li_q;
    logic             crc_zero;
    logic             buf_we;

    // packet bookkeeping
    logic             have_prev;
    logic [3:0]       prev_sn;
    logic             pkt_open;
    logic             pkt_err_q;
    logic             sn_ok;
    logic             seg_bad;
    logic             is_begin;
    logic             is_end;
    logic             accept;
    logic             close_old;
    logic [LI_W-1:0]  seg_len;

    // emission side
    logic [LI_W-1:0]  job_len;
    logic             job_done;
    logic             job_err;
    logic             sop_pend;
    em_state_e        em_state;
    em_state_e        em_next;
    logic [LI_W-1:0]  rd_idx;
    logic [7:0]       rd_byte;
    logic             emit_idle;

    always_comb begin
        byte_pos  = in_first ? '0 : rx_pos;
        take      = in_valid && (in_first || rx_act);
        seg_end   = take && (byte_pos == POS_LAST);
        buf_we    = take && (byte_pos >= POS_D0) && (byte_pos < POS_DEND);
        sn_ok     = !have_prev || (hdr_sn == prev_sn + 4'd1);
        seg_bad   = !sn_ok || !crc_zero;
        is_begin  = (hdr_type == SEG_BOM) || (hdr_type == SEG_SSM);
        is_end    = (hdr_type == SEG_EOM) || (hdr_type == SEG_SSM);
        accept    = is_begin || pkt_open;
        close_old = is_begin && pkt_open;
        seg_len   = (li_q > LI_MAX) ? LI_MAX : li_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_act   <= 1'b0;
            rx_pos   <= '0;
            hdr_type <= SEG_COM;
            hdr_sn   <= '0;
            li_q     <= '0;
        end else if (take) begin
            rx_act <= (byte_pos != POS_LAST);
            rx_pos <= (byte_pos == POS_LAST) ? '0 : byte_pos + 1'b1;
            if (byte_pos == '0) begin
                hdr_type <= seg_type_e'(in_byte[7:6]);
                hdr_sn   <= in_byte[5:2];
            end
            if (byte_pos == POS_LI) li_q <= in_byte[7:2];
        end
    end

    sar_crc10 i_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (take),
        .first    (byte_pos == '0),
        .din      (in_byte),
        .rem_zero (crc_zero)
    );

    sar_seg_buf #(.DEPTH(DATA_BYTES), .AW(AW)) i_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (AW'(byte_pos - POS_D0)),
        .wdata (in_byte),
        .raddr (AW'(rd_idx)),
        .rdata (rd_byte)
    );

    // segment verdict, taken when the trailer completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev  <= 1'b0;
            prev_sn    <= '0;
            pkt_open   <= 1'b0;
            pkt_err_q  <= 1'b0;
            job_len    <= '0;
            job_done   <= 1'b0;
            job_err    <= 1'b0;
            proto_errs <= '0;
        end else if (seg_end) begin
            have_prev <= 1'b1;
            prev_sn   <= hdr_sn;
            if (!accept) begin
                if (proto_errs != '1) proto_errs <= proto_errs + 1'b1;
            end else begin
                pkt_open  <= !is_end;
                pkt_err_q <= is_begin ? seg_bad : (pkt_err_q | seg_bad);
                job_len   <= seg_len;
                job_done  <= is_end;
                job_err   <= (is_begin ? 1'b0 : pkt_err_q) | seg_bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sop_pend <= 1'b0;
        else if (seg_end && accept && is_begin) sop_pend <= 1'b1;
        else if (em_state == EM_DATA) sop_pend <= 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_state <= EM_IDLE;
            rd_idx   <= '0;
        end else begin
            em_state <= em_next;
            rd_idx   <= (em_state == EM_DATA) ? rd_idx + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        em_next = em_state;
        unique case (em_state)
            EM_IDLE: begin
                if (seg_end && accept) begin
                    if (close_old)           em_next = EM_CLOSE;
                    else if (seg_len != '0)  em_next = EM_DATA;
                    else if (is_end)         em_next = EM_DONE;
                end
            end
            EM_CLOSE: begin
                if (job_len != '0)  em_next = EM_DATA;
                else if (job_done)  em_next = EM_DONE;
                else                em_next = EM_IDLE;
            end
            EM_DATA: begin
                if (rd_idx == job_len - 1'b1) em_next = job_done ? EM_DONE : EM_IDLE;
            end
            EM_DONE: em_next = EM_IDLE;
            default: em_next = EM_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_sop   = 1'b0;
        pkt_done  = 1'b0;
        pkt_err   = 1'b0;
        out_byte  = rd_byte;
        emit_idle = (em_state == EM_IDLE);
        unique case (em_state)
            EM_IDLE: ;
            EM_CLOSE: begin
                pkt_done = 1'b1;
                pkt_err  = 1'b1;
            end
            EM_DATA: begin
                out_valid = 1'b1;
                out_sop   = sop_pend;
            end
            EM_DONE: begin
                pkt_done = 1'b1;
                pkt_err  = job_err;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_reassembler_chk.sv
module sar_reassembler_chk #(
    parameter int DATA_BYTES = 44,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_end,
    input logic             emit_idle,
    input logic             out_valid,
    input logic             pkt_done,
    input logic             pkt_err,
    input logic [CNT_W-1:0] proto_errs
);

    localparam logic [7:0] MAX_RUN = 8'(DATA_BYTES);

    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else run_q <= out_valid ? run_q + 1'b1 : '0;
    end

    // R10
    emit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_end |-> emit_idle);

    // R9
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> pkt_done);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(proto_errs) |-> (proto_errs == CNT_W'($past(proto_errs) + 1'b1)));

    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < MAX_RUN));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !pkt_done);

endmodule

bind sar_reassembler sar_reassembler_chk #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_end    (seg_end),
    .emit_idle  (emit_idle),
    .out_valid  (out_valid),
    .pkt_done   (pkt_done),
    .pkt_err    (pkt_err),
    .proto_errs (proto_errs)
);

// File: tb/test_sar_reassembler.sv
`timescale 1ns/1ps
module test_sar_reassembler;

    localparam int SB = 48;
    localparam int NEV = 16384;
    localparam logic [1:0] T_COM = 2'b00, T_EOM = 2'b01, T_BOM = 2'b10, T_SSM = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic [7:0] in_byte = '0;
    logic       out_valid, out_sop, pkt_done, pkt_err;
    logic [7:0] out_byte;
    logic [7:0] proto_errs;

    always #2 clk = ~clk;

    sar_reassembler i_sar_reassembler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
        .out_sop(out_sop), .pkt_done(pkt_done), .pkt_err(pkt_err),
        .proto_errs(proto_errs)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0, last_tr_cyc = 0;
    int unsigned seed_q;

    logic [7:0] seg_b [SB];
    logic [7:0] ev_b [NEV];
    bit ev_sop [NEV], ev_done [NEV], ev_err [NEV], ev_adj [NEV];
    string ev_tag [NEV];
    int wr = 0, rd = 0;

    bit m_open = 0, m_err = 0, m_sopp = 0, m_have = 0, m_crc_hit = 0, m_sn_hit = 0;
    logic [3:0] m_prev = '0;
    int m_cnt = 0;
    logic [3:0] sn_nxt = '0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void push_ev(logic [7:0] b, bit sop, bit done, bit err, bit adj, string tag);
        ev_b[wr] = b; ev_sop[wr] = sop; ev_done[wr] = done;
        ev_err[wr] = err; ev_adj[wr] = adj; ev_tag[wr] = tag;
        wr++;
    endfunction

    // bitwise CRC-10 over the first 374 bits of the segment (R5)
    function automatic logic [9:0] seg_crc();
        logic [9:0] c = '0;
        for (int k = 0; k < 374; k++) begin
            bit bi = seg_b[k/8][7-(k%8)];
            bit fb = c[9] ^ bi;
            c = {c[8:0], 1'b0};
            if (fb) c = c ^ 10'h233;
        end
        return c;
    endfunction

    function automatic string done_tag();
        if (m_crc_hit) return "R5";
        if (m_sn_hit) return "R6";
        return "R9";
    endfunction

    function automatic void push_data(int n, string tagb);
        for (int i = 0; i < n; i++) begin
            push_ev(seg_b[2+i], m_sopp, 0, 0, 0, m_sopp ? "R4" : tagb);
            m_sopp = 0;
        end
    endfunction

    function automatic void drop_seg();
        if (m_cnt < 255) m_cnt++;
    endfunction

    task automatic send_seg(input logic [1:0] ty, input logic [3:0] sn, input logic [5:0] li,
                            input bit corrupt, input int gap);
        logic [9:0] crc;
        int n, fi, fbit;
        bit sn_bad, bad;
        string tagb;
        seg_b[0] = {ty, sn, 2'($urandom)};
        seg_b[1] = 8'($urandom);
        for (int i = 2; i < 46; i++) seg_b[i] = 8'($urandom);
        seg_b[46] = {li, 2'b00};
        crc = seg_crc();
        seg_b[46][1:0] = crc[9:8];
        seg_b[47] = crc[7:0];
        if (corrupt) begin
            fi = 2 + int'($urandom_range(43, 0));
            fbit = int'($urandom_range(7, 0));
            seg_b[fi][fbit] = ~seg_b[fi][fbit];
        end
        sn_bad = m_have && (sn != 4'(m_prev + 4'd1));
        bad = corrupt || sn_bad;
        m_prev = sn; m_have = 1;
        n = (li > 6'd44) ? 44 : int'(li);
        tagb = (li > 6'd44) ? "R3" : "R2";
        case (ty)
            T_BOM: begin
                if (m_open) push_ev(0, 0, 1, 1, 0, "R8");
                m_open = 1; m_err = bad; m_crc_hit = corrupt; m_sn_hit = sn_bad; m_sopp = 1;
                push_data(n, tagb);
            end
            T_COM: begin
                if (!m_open) drop_seg();
                else begin
                    m_err |= bad; m_crc_hit |= corrupt; m_sn_hit |= sn_bad;
                    push_data(n, tagb);
                end
            end
            T_EOM: begin
                if (!m_open) drop_seg();
                else begin
                    m_err |= bad; m_crc_hit |= corrupt; m_sn_hit |= sn_bad;
                    push_data(n, tagb);
                    push_ev(0, 0, 1, m_err, n > 0, done_tag());
                    m_open = 0;
                end
            end
            default: begin
                if (m_open) push_ev(0, 0, 1, 1, 0, "R8");
                m_err = bad; m_crc_hit = corrupt; m_sn_hit = sn_bad; m_sopp = 1;
                push_data(n, tagb);
                push_ev(0, 0, 1, m_err, n > 0, done_tag());
                m_open = 0;
            end
        endcase
        for (int i = 0; i < SB; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = (i == 0);
            in_byte = seg_b[i];
            if (i == SB - 1) last_tr_cyc = cyc;
        end
        if (gap > 0) begin
            @(negedge clk);
            in_valid = 1'b0; in_first = 1'b0;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic seg(input logic [1:0] ty, input logic [5:0] li, input bit corrupt, input int gap);
        send_seg(ty, sn_nxt, li, corrupt, gap);
        sn_nxt = sn_nxt + 4'd1;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_raw(input int n, input bit with_first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_first = with_first && (i == 0);
            in_byte = 8'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    // output monitor
    initial begin
        bit prev_valid = 0, prev_done = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (rst_n) begin
                if (out_valid) begin
                    if (rd >= wr || ev_done[rd]) check(0, "R4", "unexpected data beat", 1, 0);
                    else begin
                        check(out_byte == ev_b[rd], ev_tag[rd], "data byte", out_byte, ev_b[rd]);
                        check(out_sop == ev_sop[rd], "R4", "out_sop", out_sop, ev_sop[rd]);
                        if (!prev_valid)
                            check(cyc == last_tr_cyc + 1 + int'(prev_done), "R10", "first byte cycle",
                                  cyc, last_tr_cyc + 1 + int'(prev_done));
                        rd++;
                    end
                end
                if (pkt_done) begin
                    if (rd >= wr || !ev_done[rd]) check(0, "R4", "unexpected pkt_done", 1, 0);
                    else begin
                        check(pkt_err == ev_err[rd], ev_tag[rd], "pkt_err", pkt_err, ev_err[rd]);
                        if (ev_adj[rd]) check(prev_valid, "R9", "done after last byte", prev_valid, 1);
                        rd++;
                    end
                end
                if (!pkt_done && pkt_err) check(0, "R9", "pkt_err without done", 1, 0);
            end
            prev_valid = out_valid;
            prev_done = pkt_done;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        seed_q = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(pkt_done == 1'b0, "R1", "pkt_done after reset", pkt_done, 0);
        check(proto_errs == 8'd0, "R1", "proto_errs after reset", proto_errs, 0);

        // R11: stray bytes and a truncated segment are ignored
        send_raw(6, 0);
        send_raw(20, 1);
        idle(4);
        check(proto_errs == 8'd0, "R11", "proto_errs after stray bytes", proto_errs, 0);
        check(wr == rd, "R11", "no output from stray bytes", rd, wr);

        seg(T_SSM, 6'd10, 0, 0);          // R4 single, first SN unchecked
        seg(T_BOM, 6'd44, 0, 0);          // R2 full field
        seg(T_COM, 6'd60, 0, 0);          // R3 clamp
        seg(T_EOM, 6'd0, 0, 3);           // R9 done without data
        seg(T_COM, 6'd20, 0, 1);          // R7 stray continue
        seg(T_EOM, 6'd5, 0, 1);           // R7 stray end
        seg(T_BOM, 6'd7, 0, 0);
        seg(T_BOM, 6'd9, 0, 0);           // R8 abort open packet
        seg(T_EOM, 6'd3, 0, 2);
        seg(T_BOM, 6'd4, 0, 0);
        sn_nxt = sn_nxt + 4'd2;
        seg(T_COM, 6'd4, 0, 0);           // R6 sequence gap
        seg(T_EOM, 6'd4, 0, 0);
        seg(T_SSM, 6'd12, 1, 0);          // R5 corrupted segment
        seg(T_SSM, 6'd0, 0, 0);           // R9 single with no data
        idle(60);
        check(wr == rd, "R4", "directed events delivered", rd, wr);
        check(int'(proto_errs) == m_cnt, "R7", "proto_errs directed", proto_errs, m_cnt);

        for (int s = 0; s < 150; s++) begin
            logic [1:0] ty = 2'($urandom);
            logic [5:0] li = ($urandom_range(9, 0) < 8) ? 6'($urandom_range(44, 0)) : 6'($urandom_range(63, 45));
            bit cor = ($urandom_range(9, 0) == 0);
            if ($urandom_range(9, 0) == 0) sn_nxt = 4'($urandom);
            seg(ty, li, cor, int'($urandom_range(3, 0)));
        end
        idle(60);
        check(wr == rd, "R4", "random events delivered", rd, wr);
        check(int'(proto_errs) == m_cnt, "R7", "proto_errs random", proto_errs, m_cnt);

        seg(T_SSM, 6'd1, 0, 0);
        for (int s = 0; s < 260; s++) seg(T_COM, 6'd8, 0, 0);
        idle(60);
        check(proto_errs == 8'd255, "R7", "proto_errs saturation", proto_errs, 255);
        check(wr == rd, "R7", "dropped segments produce no output", rd, wr);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule